// File: doc/BRIEF.md
# Interrupt Entry and Return Sequencer

This block runs the processor's side of taking an interrupt and of leaving one. When the arbitration logic grants an interrupt (`int_go`), the sequencer records the program counter, the flag word, the stack pointer, the granted level, the vector table base and the prefetch-queue condition. It then issues a fixed run of bus cycles. First comes a slot that is a prefetch read only if the queue could accept an instruction. Then it reads the interrupt information word at address 0 and pushes the saved flags and PC onto the stack. It updates the stack pointer and the flag word (interrupts masked, level raised), fetches the two handler vector words and loads the new PC.

On `ret_go`, the block reverses the push. It pops the PC low word, then the flag/PC-high word, and restores the PC, the flag word and the stack pointer in one cycle. The caller only raises a one-cycle start and waits for `done`.

States: `ST_IDLE`, `ST_QSLOT`, `ST_INFO`, `ST_PUSH_HI`, `ST_PUSH_LO`, `ST_SAVE`, `ST_VEC_LO`, `ST_VEC_HI`, `ST_ENTER`, `ST_POP_LO`, `ST_POP_HI`, `ST_RESUME`.

Transitions:
- IDLE to QSLOT on `int_go`, else to POP_LO on `ret_go`.
- Entry path: QSLOT, INFO, PUSH_HI, PUSH_LO, SAVE, VEC_LO, VEC_HI, ENTER, then IDLE.
- Return path: POP_LO, POP_HI, RESUME, then IDLE.
- A state with a bus cycle stays put until `bus_rdy`. QSLOT with the queue full, SAVE, ENTER and RESUME last exactly one cycle.

Top module: `irq_seq`

## Requirements
- R1: After reset the block is idle. `busy` and `done` are low, and it raises no bus strobe and no update strobe (`sp_we`, `flg_we`, `pc_we`) while idle.
- R2: The first entry cycle reads at the PC captured at `int_go` when `q_take` was 1 at that moment. When `q_take` was 0, that cycle issues no bus strobe. Inputs changed after the start do not affect the sequence.
- R3: The next entry cycle reads address 0. Bits [5:0] of the returned word are the vector index.
- R4: The entry then writes `{flags[11:0], pc[19:16]}` at SP-2, and afterwards `pc[15:0]` at SP-4.
- R5: In the cycle after the second push, `sp_we` is high with `sp_out` = SP-4. In the same cycle `flg_we` is high and `flg_out` equals the saved flags with bit 6 (enable) cleared and bits [11:9] (level) set to the granted level.
- R6: The entry then reads the vector at `vec_base + 4*index`, and afterwards at that address plus 2.
- R7: The new PC is `{high_vector_word[3:0], low_vector_word}`. It is presented with `pc_we` and a single-cycle `done` in the cycle after the second vector read.
- R8: A bus cycle keeps its address, write data and strobe unchanged until `bus_rdy` is high, and the sequence does not advance before then.
- R9: A return reads at SP, then at SP+2. In the following cycle it asserts `pc_we`, `flg_we`, `sp_we` and `done`, with the PC and flags decoded from those words as pushed and `sp_out` = SP+4.
- R10: `int_go` takes precedence over `ret_go` in the same cycle. Start requests while busy are ignored.
- R11: `bus_rd` and `bus_wr` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| int_go | input | 1 | Interrupt granted, start entry |
| ret_go | input | 1 | Start return from interrupt |
| q_take | input | 1 | Prefetch queue can accept an instruction |
| acc_lvl | input | 3 | Level of the granted interrupt |
| pc_in | input | 20 | Current program counter |
| flg_in | input | 12 | Current flag word |
| sp_in | input | 20 | Current stack pointer |
| vec_base | input | 20 | Base of the vector table |
| bus_addr | output | 20 | Bus address |
| bus_wdata | output | 16 | Bus write data |
| bus_rd | output | 1 | Read strobe |
| bus_wr | output | 1 | Write strobe |
| bus_rdata | input | 16 | Bus read data |
| bus_rdy | input | 1 | Bus cycle completes this clock |
| sp_we | output | 1 | Stack pointer update strobe |
| sp_out | output | 20 | New stack pointer |
| flg_we | output | 1 | Flag word update strobe |
| flg_out | output | 12 | New flag word |
| pc_we | output | 1 | Program counter load strobe |
| pc_out | output | 20 | New program counter |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Sequence finished (one cycle) |

## Verification
Entry and return can be requested in the same cycle. The bench raises `int_go` and `ret_go` together while idle, and again partway through an entry. The scoreboard holds only the entry's bus cycles and updates, so any pop or extra transaction from the losing or late request shows up as an unexpected or mismatched item. Wait states from the bus model stretch each cycle, so the held address is compared on every waiting clock as well as at completion.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_QSLOT,
        ST_INFO,
        ST_PUSH_HI,
        ST_PUSH_LO,
        ST_SAVE,
        ST_VEC_LO,
        ST_VEC_HI,
        ST_ENTER,
        ST_POP_LO,
        ST_POP_HI,
        ST_RESUME
    } seq_state_t;

    typedef enum logic [1:0] {
        CYC_NONE,
        CYC_READ,
        CYC_WRITE
    } cyc_kind_t;

    // Kind of bus cycle a state issues; the queue slot reads only when allowed.
    function automatic cyc_kind_t cyc_of(input seq_state_t s, input logic qslot_rd);
        cyc_kind_t k;
        unique case (s)
            ST_QSLOT:                         k = qslot_rd ? CYC_READ : CYC_NONE;
            ST_INFO, ST_VEC_LO, ST_VEC_HI,
            ST_POP_LO, ST_POP_HI:             k = CYC_READ;
            ST_PUSH_HI, ST_PUSH_LO:           k = CYC_WRITE;
            default:                          k = CYC_NONE;
        endcase
        return k;
    endfunction

endpackage

// File: rtl/irq_seq_fsm.sv
module irq_seq_fsm
    import irq_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       int_go,
    input  logic       ret_go,
    input  logic       q_snap,
    input  logic       bus_rdy,
    output seq_state_t state_o,
    output logic       accept_o
);

    seq_state_t state_q;
    seq_state_t state_d;
    logic       step;

    assign step     = (cyc_of(state_q, q_snap) == CYC_NONE) || bus_rdy;
    assign accept_o = (state_q == ST_IDLE) && (int_go || ret_go);
    assign state_o  = state_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (int_go) begin
                    state_d = ST_QSLOT;
                end else if (ret_go) begin
                    state_d = ST_POP_LO;
                end
            end
            ST_QSLOT:   if (step) state_d = ST_INFO;
            ST_INFO:    if (step) state_d = ST_PUSH_HI;
            ST_PUSH_HI: if (step) state_d = ST_PUSH_LO;
            ST_PUSH_LO: if (step) state_d = ST_SAVE;
            ST_SAVE:    state_d = ST_VEC_LO;
            ST_VEC_LO:  if (step) state_d = ST_VEC_HI;
            ST_VEC_HI:  if (step) state_d = ST_ENTER;
            ST_ENTER:   state_d = ST_IDLE;
            ST_POP_LO:  if (step) state_d = ST_POP_HI;
            ST_POP_HI:  if (step) state_d = ST_RESUME;
            ST_RESUME:  state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

endmodule

// File: rtl/irq_seq_hold.sv
module irq_seq_hold
    import irq_seq_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 16,
    parameter int PC_W   = 20,
    parameter int FLG_W  = 12,
    parameter int LVL_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  seq_state_t        state,
    input  logic              accept,
    input  logic              bus_rdy,
    input  logic [DATA_W-1:0] bus_rdata,
    input  logic              q_take,
    input  logic [LVL_W-1:0]  acc_lvl,
    input  logic [PC_W-1:0]   pc_in,
    input  logic [FLG_W-1:0]  flg_in,
    input  logic [ADDR_W-1:0] sp_in,
    input  logic [ADDR_W-1:0] vec_base,
    output logic              q_snap,
    output logic [LVL_W-1:0]  lvl_q,
    output logic [PC_W-1:0]   pc_q,
    output logic [FLG_W-1:0]  flg_q,
    output logic [ADDR_W-1:0] sp_q,
    output logic [ADDR_W-1:0] vb_q,
    output logic [DATA_W-1:0] info_q,
    output logic [DATA_W-1:0] lo_q,
    output logic [DATA_W-1:0] hi_q
);

    logic take_info;
    logic take_lo;
    logic take_hi;

    assign take_info = bus_rdy && (state == ST_INFO);
    assign take_lo   = bus_rdy && ((state == ST_VEC_LO) || (state == ST_POP_LO));
    assign take_hi   = bus_rdy && ((state == ST_VEC_HI) || (state == ST_POP_HI));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_snap <= 1'b0;
            lvl_q  <= '0;
            pc_q   <= '0;
            flg_q  <= '0;
            sp_q   <= '0;
            vb_q   <= '0;
        end else if (accept) begin
            q_snap <= q_take;
            lvl_q  <= acc_lvl;
            pc_q   <= pc_in;
            flg_q  <= flg_in;
            sp_q   <= sp_in;
            vb_q   <= vec_base;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            info_q <= '0;
            lo_q   <= '0;
            hi_q   <= '0;
        end else begin
            if (take_info) info_q <= bus_rdata;
            if (take_lo)   lo_q   <= bus_rdata;
            if (take_hi)   hi_q   <= bus_rdata;
        end
    end

endmodule

// File: rtl/irq_seq_bus.sv
module irq_seq_bus
    import irq_seq_pkg::*;
#(
    parameter int ADDR_W    = 20,
    parameter int DATA_W    = 16,
    parameter int PC_W      = 20,
    parameter int FLG_W     = 12,
    parameter int VEC_IDX_W = 6
) (
    input  seq_state_t        state,
    input  logic              q_snap,
    input  logic [PC_W-1:0]   pc_q,
    input  logic [FLG_W-1:0]  flg_q,
    input  logic [ADDR_W-1:0] sp_q,
    input  logic [ADDR_W-1:0] vb_q,
    input  logic [DATA_W-1:0] info_q,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    output logic              bus_rd,
    output logic              bus_wr
);

    localparam int PC_HI_W = PC_W - DATA_W;

    logic [ADDR_W-1:0] vec_addr;
    logic [DATA_W-1:0] hi_word;
    cyc_kind_t         kind;

    assign vec_addr = vb_q + ADDR_W'({info_q[VEC_IDX_W-1:0], 2'b00});
    assign hi_word  = DATA_W'({flg_q, pc_q[PC_W-1 -: PC_HI_W]});
    assign kind     = cyc_of(state, q_snap);
    assign bus_rd   = (kind == CYC_READ);
    assign bus_wr   = (kind == CYC_WRITE);

    always_comb begin
        bus_addr  = '0;
        bus_wdata = '0;
        unique case (state)
            ST_QSLOT:   bus_addr = q_snap ? ADDR_W'(pc_q) : '0;
            ST_INFO:    bus_addr = '0;
            ST_PUSH_HI: begin
                bus_addr  = sp_q - ADDR_W'(2);
                bus_wdata = hi_word;
            end
            ST_PUSH_LO: begin
                bus_addr  = sp_q - ADDR_W'(4);
                bus_wdata = pc_q[DATA_W-1:0];
            end
            ST_VEC_LO:  bus_addr = vec_addr;
            ST_VEC_HI:  bus_addr = vec_addr + ADDR_W'(2);
            ST_POP_LO:  bus_addr = sp_q;
            ST_POP_HI:  bus_addr = sp_q + ADDR_W'(2);
            default: begin
                bus_addr  = '0;
                bus_wdata = '0;
            end
        endcase
    end

endmodule

// File: rtl/irq_seq.sv
module irq_seq
    import irq_seq_pkg::*;
#(
    parameter int ADDR_W    = 20,
    parameter int DATA_W    = 16,
    parameter int PC_W      = 20,
    parameter int FLG_W     = 12,
    parameter int LVL_W     = 3,
    parameter int I_BIT     = 6,
    parameter int IPL_LSB   = 9,
    parameter int VEC_IDX_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              int_go,
    input  logic              ret_go,
    input  logic              q_take,
    input  logic [LVL_W-1:0]  acc_lvl,
    input  logic [PC_W-1:0]   pc_in,
    input  logic [FLG_W-1:0]  flg_in,
    input  logic [ADDR_W-1:0] sp_in,
    input  logic [ADDR_W-1:0] vec_base,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    output logic              bus_rd,
    output logic              bus_wr,
    input  logic [DATA_W-1:0] bus_rdata,
    input  logic              bus_rdy,
    output logic              sp_we,
    output logic [ADDR_W-1:0] sp_out,
    output logic              flg_we,
    output logic [FLG_W-1:0]  flg_out,
    output logic              pc_we,
    output logic [PC_W-1:0]   pc_out,
    output logic              busy,
    output logic              done
);

    localparam int PC_HI_W = PC_W - DATA_W;

    seq_state_t        state;
    logic              accept;
    logic              q_snap;
    logic [LVL_W-1:0]  lvl_q;
    logic [PC_W-1:0]   pc_q;
    logic [FLG_W-1:0]  flg_q;
    logic [ADDR_W-1:0] sp_q;
    logic [ADDR_W-1:0] vb_q;
    logic [DATA_W-1:0] info_q;
    logic [DATA_W-1:0] lo_q;
    logic [DATA_W-1:0] hi_q;
    logic [FLG_W-1:0]  masked_flg;
    logic [PC_W-1:0]   joined_pc;

    irq_seq_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .int_go   (int_go),
        .ret_go   (ret_go),
        .q_snap   (q_snap),
        .bus_rdy  (bus_rdy),
        .state_o  (state),
        .accept_o (accept)
    );

    irq_seq_hold #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .PC_W   (PC_W),
        .FLG_W  (FLG_W),
        .LVL_W  (LVL_W)
    ) u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .state     (state),
        .accept    (accept),
        .bus_rdy   (bus_rdy),
        .bus_rdata (bus_rdata),
        .q_take    (q_take),
        .acc_lvl   (acc_lvl),
        .pc_in     (pc_in),
        .flg_in    (flg_in),
        .sp_in     (sp_in),
        .vec_base  (vec_base),
        .q_snap    (q_snap),
        .lvl_q     (lvl_q),
        .pc_q      (pc_q),
        .flg_q     (flg_q),
        .sp_q      (sp_q),
        .vb_q      (vb_q),
        .info_q    (info_q),
        .lo_q      (lo_q),
        .hi_q      (hi_q)
    );

    irq_seq_bus #(
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W),
        .PC_W      (PC_W),
        .FLG_W     (FLG_W),
        .VEC_IDX_W (VEC_IDX_W)
    ) u_bus (
        .state     (state),
        .q_snap    (q_snap),
        .pc_q      (pc_q),
        .flg_q     (flg_q),
        .sp_q      (sp_q),
        .vb_q      (vb_q),
        .info_q    (info_q),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rd    (bus_rd),
        .bus_wr    (bus_wr)
    );

    // Mask interrupts and raise the level to the granted one.
    always_comb begin
        masked_flg                        = flg_q;
        masked_flg[I_BIT]                 = 1'b0;
        masked_flg[IPL_LSB +: LVL_W]      = lvl_q;
    end

    // Both the vector pair and the popped pair carry the PC as {hi[low bits], lo}.
    assign joined_pc = {hi_q[PC_HI_W-1:0], lo_q};

    always_comb begin
        sp_we   = 1'b0;
        sp_out  = '0;
        flg_we  = 1'b0;
        flg_out = '0;
        pc_we   = 1'b0;
        pc_out  = '0;
        done    = 1'b0;
        busy    = (state != ST_IDLE);
        unique case (state)
            ST_SAVE: begin
                sp_we   = 1'b1;
                sp_out  = sp_q - ADDR_W'(4);
                flg_we  = 1'b1;
                flg_out = masked_flg;
            end
            ST_ENTER: begin
                pc_we  = 1'b1;
                pc_out = joined_pc;
                done   = 1'b1;
            end
            ST_RESUME: begin
                pc_we   = 1'b1;
                pc_out  = joined_pc;
                flg_we  = 1'b1;
                flg_out = hi_q[PC_HI_W +: FLG_W];
                sp_we   = 1'b1;
                sp_out  = sp_q + ADDR_W'(4);
                done    = 1'b1;
            end
            default: begin
                done = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/irq_seq_chk.sv
module irq_seq_chk #(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 16,
    parameter int FLG_W  = 12,
    parameter int I_BIT  = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              int_go,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              bus_rd,
    input logic              bus_wr,
    input logic              bus_rdy,
    input logic              sp_we,
    input logic              flg_we,
    input logic [FLG_W-1:0]  flg_out,
    input logic              pc_we,
    input logic              busy,
    input logic              done
);

    p_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_rd && bus_wr));

    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((bus_rd || bus_wr) && !bus_rdy) |=>
            (bus_rd == $past(bus_rd)) && (bus_wr == $past(bus_wr)) &&
            $stable(bus_addr) && $stable(bus_wdata));

    p_quiet_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !(bus_rd || bus_wr || sp_we || flg_we || pc_we || done));

    p_done_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> pc_we);

    p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_mask_on_entry_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (flg_we && !done) |-> !flg_out[I_BIT]);

    p_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && int_go) |=> (busy && !bus_wr));

endmodule

bind irq_seq irq_seq_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .FLG_W  (FLG_W),
    .I_BIT  (I_BIT)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .int_go    (int_go),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rd    (bus_rd),
    .bus_wr    (bus_wr),
    .bus_rdy   (bus_rdy),
    .sp_we     (sp_we),
    .flg_we    (flg_we),
    .flg_out   (flg_out),
    .pc_we     (pc_we),
    .busy      (busy),
    .done      (done)
);

// File: tb/irq_seq_test.sv
module irq_seq_test;

    localparam int CLK_PERIOD = 10;
    localparam logic [19:0] VBASE = 20'h00010;

    // Event kinds: 0 read, 1 write, 2 sp update, 3 flag update, 4 pc load
    typedef struct {
        int          kind;
        logic [19:0] addr;
        logic [15:0] data;
        string       req;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        int_go = 1'b0;
    logic        ret_go = 1'b0;
    logic        q_take = 1'b0;
    logic [2:0]  acc_lvl = '0;
    logic [19:0] pc_in = '0;
    logic [11:0] flg_in = '0;
    logic [19:0] sp_in = '0;
    logic [19:0] vec_base = VBASE;
    logic [19:0] bus_addr;
    logic [15:0] bus_wdata;
    logic        bus_rd;
    logic        bus_wr;
    logic [15:0] bus_rdata;
    logic        bus_rdy;
    logic        sp_we;
    logic [19:0] sp_out;
    logic        flg_we;
    logic [11:0] flg_out;
    logic        pc_we;
    logic [19:0] pc_out;
    logic        busy;
    logic        done;

    int checks = 0;
    int fails  = 0;
    bit live   = 0;
    bit ended  = 0;
    int wait_len = 0;
    int wcnt = 0;
    logic [15:0] mem [128];
    exp_t exq[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_seq uut (
        .clk(clk), .rst_n(rst_n), .int_go(int_go), .ret_go(ret_go),
        .q_take(q_take), .acc_lvl(acc_lvl), .pc_in(pc_in), .flg_in(flg_in),
        .sp_in(sp_in), .vec_base(vec_base), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_rdata(bus_rdata), .bus_rdy(bus_rdy), .sp_we(sp_we),
        .sp_out(sp_out), .flg_we(flg_we), .flg_out(flg_out), .pc_we(pc_we),
        .pc_out(pc_out), .busy(busy), .done(done)
    );

    // Bus model: small word memory with a programmable number of wait states.
    assign bus_rdy   = (bus_rd || bus_wr) && (wcnt == wait_len);
    assign bus_rdata = mem[bus_addr[7:1]];

    always @(posedge clk) begin
        if ((bus_rd || bus_wr) && !bus_rdy) wcnt <= wcnt + 1;
        else wcnt <= 0;
        if (bus_wr && bus_rdy) mem[bus_addr[7:1]] <= bus_wdata;
    end

    function automatic logic [11:0] entry_flags(input logic [11:0] f, input logic [2:0] l);
        logic [11:0] r;
        r = f;
        r[6] = 1'b0;
        r[11:9] = l;
        return r;
    endfunction

    function automatic void expect_ev(input int k, input logic [19:0] a,
                                      input logic [15:0] d, input string rq);
        exp_t e;
        e.kind = k; e.addr = a; e.data = d; e.req = rq;
        exq.push_back(e);
    endfunction

    task automatic match(input int k, input logic [19:0] a, input logic [15:0] d, input bit pop);
        checks++;
        if (exq.size() == 0) begin
            fails++;
            $display("FAIL R10 unexpected event: kind %0d addr %h data %h, expected none", k, a, d);
        end else begin
            if (exq[0].kind != k || exq[0].addr != a || exq[0].data != d) begin
                fails++;
                $display("FAIL %s event: kind %0d addr %h data %h, expected kind %0d addr %h data %h",
                         exq[0].req, k, a, d, exq[0].kind, exq[0].addr, exq[0].data);
            end
            if (pop) void'(exq.pop_front());
        end
    endtask

    // Monitor: compares activity against the scoreboard queue, order bus, sp, flag, pc.
    always @(negedge clk) begin
        if (live && rst_n) begin
            if (bus_rd) match(0, bus_addr, 16'h0, bus_rdy);
            if (bus_wr) match(1, bus_addr, bus_wdata, bus_rdy);
            if (sp_we)  match(2, sp_out, 16'h0, 1'b1);
            if (flg_we) match(3, 20'h0, {4'h0, flg_out}, 1'b1);
            if (pc_we)  match(4, pc_out, 16'h0, 1'b1);
            if (done != pc_we) begin
                checks++;
                fails++;
                $display("FAIL R7 done=%0b while pc_we=%0b, expected equal", done, pc_we);
            end
        end
    end

    task automatic pulse(input bit e, input bit r);
        @(posedge clk); #1;
        int_go = e; ret_go = r;
        @(posedge clk); #1;
        int_go = 1'b0; ret_go = 1'b0;
    endtask

    task automatic finish_seq(input string rq);
        do @(negedge clk); while (!done);
        repeat (3) @(negedge clk);
        checks++;
        if (exq.size() != 0 || busy) begin
            fails++;
            $display("FAIL %s sequence left %0d expected items, busy=%0b, expected 0 and 0",
                     rq, exq.size(), busy);
            exq.delete();
        end
    endtask

    task automatic do_entry(input logic [19:0] pc, input logic [11:0] fl, input logic [19:0] sp,
                            input logic [2:0] lv, input bit q, input logic [15:0] info,
                            input logic [15:0] vlo, input logic [15:0] vhi, input int w,
                            input bit both, input bit poke);
        logic [19:0] va;
        va = VBASE + {12'h0, info[5:0], 2'b00};
        mem[0] = info;
        mem[va[7:1]] = vlo;
        mem[(va + 20'd2) >> 1 & 20'h7F] = vhi;
        wait_len = w;
        pc_in = pc; flg_in = fl; sp_in = sp; acc_lvl = lv; q_take = q;
        if (q) expect_ev(0, pc, 16'h0, "R2");
        expect_ev(0, 20'h0, 16'h0, "R3");
        expect_ev(1, sp - 20'd2, {fl, pc[19:16]}, "R4");
        expect_ev(1, sp - 20'd4, pc[15:0], "R4");
        expect_ev(2, sp - 20'd4, 16'h0, "R5");
        expect_ev(3, 20'h0, {4'h0, entry_flags(fl, lv)}, "R5");
        expect_ev(0, va, 16'h0, "R6");
        expect_ev(0, va + 20'd2, 16'h0, "R6");
        expect_ev(4, {vhi[3:0], vlo}, 16'h0, "R7");
        pulse(1'b1, both);
        // Inputs move after the start; the sequence must use the captured values (R2).
        pc_in = ~pc; flg_in = ~fl; sp_in = sp + 20'h100; acc_lvl = ~lv; q_take = ~q;
        if (poke) begin
            repeat (2) @(posedge clk);
            pulse(1'b1, 1'b1);  // R10: ignored while busy
        end
        finish_seq("R7");
    endtask

    task automatic do_return(input logic [19:0] sp, input logic [19:0] pc,
                             input logic [11:0] fl, input int w);
        wait_len = w;
        sp_in = sp;
        expect_ev(0, sp, 16'h0, "R9");
        expect_ev(0, sp + 20'd2, 16'h0, "R9");
        expect_ev(2, sp + 20'd4, 16'h0, "R9");
        expect_ev(3, 20'h0, {4'h0, fl}, "R9");
        expect_ev(4, pc, 16'h0, "R9");
        pulse(1'b0, 1'b1);
        sp_in = 20'hFFFFF;
        finish_seq("R9");
    endtask

    initial begin
        for (int i = 0; i < 128; i++) mem[i] = 16'h0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        checks++;
        if (busy || done || bus_rd || bus_wr || sp_we || flg_we || pc_we) begin
            fails++;
            $display("FAIL R1 reset state busy=%0b done=%0b rd=%0b wr=%0b, expected all 0",
                     busy, done, bus_rd, bus_wr);
        end
        live = 1;
        repeat (3) @(negedge clk);  // R1: idle stays quiet, monitor flags any event

        // Queue can take: prefetch read first, no waits
        do_entry(20'h5A3C4, 12'h0C5, 20'h000C0, 3'd5, 1'b1, 16'h0003, 16'h1234, 16'h0007, 0, 1'b0, 1'b0);
        do_return(20'h000BC, 20'h5A3C4, 12'h0C5, 1);

        // Queue full: idle slot, wait states (R8), top vector index, late start requests (R10)
        do_entry(20'h0F00E, 12'hFFF, 20'h000A0, 3'd7, 1'b0, 16'h00FF, 16'hBEEF, 16'h000A, 2, 1'b0, 1'b1);
        do_return(20'h0009C, 20'h0F00E, 12'hFFF, 2);

        // Both starts in the same idle cycle: entry wins (R10)
        do_entry(20'h00002, 12'h040, 20'h00060, 3'd0, 1'b1, 16'h0001, 16'h0100, 16'h000F, 1, 1'b1, 1'b0);
        do_return(20'h0005C, 20'h00002, 12'h040, 0);

        ended = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!ended) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired, sequence hung, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule